// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the slave side of a two-wire serial memory. It holds a byte array that is filled through a parallel backdoor port, and it answers the read transactions a bus master issues on SCL and SDA. SCL and SDA come from the pads and are resynchronized to a fast system clock. Every bus event (clock edges, START, STOP) is found by looking for edges on the system clock. The block pulls SDA low for acknowledge bits and for zero data bits, and otherwise leaves the line released.

Three read forms are served. A current-address read returns the byte at a persistent address counter. A random read first performs a dummy write that carries a two-byte word address, and then a repeated START with a read-mode select. A sequential read keeps returning consecutive bytes for as long as the master acknowledges them. The counter advances once for every byte handed out and keeps its value between transactions. Data bytes that follow the word address in a write are acknowledged and then discarded.

Top module: `twimem_read_slave`

## Requirements
- R1: After reset SDA is released (`sdaDriveLow` = 0) and the address counter is 0, so the first current-address read returns the byte stored at address 0.
- R2: START is SDA falling while synchronized SCL is high, and STOP is SDA rising while SCL is high. A STOP releases SDA on the next system clock and returns the block to idle. A START at any point abandons the transfer in progress and begins receiving a new select byte, leaving the counter as it was.
- R3: The select byte is sent MSB first. It is acknowledged only when its upper seven bits equal `1010` followed by `chipSel[2:0]`; bit 0 is the read/write flag (1 = read). On a mismatch SDA stays released during the ninth clock and the block ignores the bus until the next START or STOP.
- R4: After a write-mode select, two word-address bytes are received high byte first and each one is acknowledged. The low 12 bits of {high, low} are loaded into the counter once the low byte is complete. A following repeated START and read-mode select return the byte at that address.
- R5: A current-address read (START followed by a read-mode select) returns the byte at the counter. The counter keeps its value across STOP.
- R6: Each byte handed out advances the counter by one, and the counter wraps from 0xFFF to 0x000.
- R7: While the master acknowledges (SDA low in the ninth clock), the next sequential byte follows. A NACK (SDA high) ends the output and leaves SDA released.
- R8: In a random read, a repeated read-mode select whose upper seven bits differ from those of the preceding write-mode select is not acknowledged. This holds even when it matches the current `chipSel`.
- R9: In write mode, data bytes after the two address bytes are acknowledged, are not stored and do not move the counter.
- R10: The `writeCtl` input has no effect on any read.
- R11: The block changes its SDA drive only while SCL is low, and it holds an acknowledge low through the whole ninth clock.
- R12: A backdoor write with `loadEn` high stores `loadData` at `loadAddr` on the rising clock edge, and later reads return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level seen at the pad |
| sdaIn | input | 1 | SDA level seen at the pad (wired-AND bus value) |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| chipSel | input | 3 | Chip-enable bits compared with select bits 3:1 |
| writeCtl | input | 1 | Write-control pin, without effect on reads |
| loadEn | input | 1 | Backdoor write enable |
| loadAddr | input | 12 | Backdoor write address |
| loadData | input | 8 | Backdoor write data |

## Verification
The hardest case to reach from the ports is a repeated select that matches the chip-enable pins but not the select sent before the repeated START. The bench gets there by changing `chipSel` during SCL low, after the dummy write's address has been acknowledged. It then sends a read select built from the new pin value and expects a NACK, followed by a current-address read that shows the cut-off dummy write still loaded the counter. A second hard case is a START that arrives between the two address bytes. It is reached by issuing a repeated START straight after the high address byte, and the read that follows must come from the unchanged counter.

// File: rtl/twimem_pkg.sv
package twimem_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [1:0] {
    SDA_REL  = 2'd0,
    SDA_ACK  = 2'd1,
    SDA_DATA = 2'd2
  } sdaMode_t;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_DEV      = 4'd1,
    ST_DEV_ACK  = 4'd2,
    ST_AHI      = 4'd3,
    ST_AHI_ACK  = 4'd4,
    ST_ALO      = 4'd5,
    ST_ALO_ACK  = 4'd6,
    ST_WDAT     = 4'd7,
    ST_WDAT_ACK = 4'd8,
    ST_TX       = 4'd9,
    ST_MACK     = 4'd10
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBit;   // zero the bit counter
    logic shiftIn;  // take one received bit
    logic loadTx;   // fetch byte at counter, advance counter, start driving data
    logic shiftTx;  // present next transmit bit
    logic latchHi;  // keep high address byte
    logic loadAddr; // load counter from {high, low}
    logic saveDev;  // remember select bits for the repeated select
    logic drvAck;   // pull SDA low for an acknowledge
    logic relSda;   // release SDA
  } dpStrobe_t;

endpackage

// File: rtl/twimem_datapath.sv
module twimem_datapath
  import twimem_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        chipSel,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  input  dpStrobe_t         strb,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaSync,
  output logic              rwBit,
  output logic [3:0]        bitCnt,
  output logic              devMatch,
  output logic              sameDev,
  output logic              sdaDriveLow
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  // ---------------- synchronizers and edge detection ----------------
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclSync, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclSync  = sclPipe[SYNC_STAGES-1];
  assign sdaSync  = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;

  // ---------------- byte array and backdoor ----------------
  logic [7:0] memArr [DEPTH];

  always_ff @(posedge clk) begin
    if (loadEn) memArr[loadAddr] <= loadData;
  end

  // ---------------- shift registers, counter, address ----------------
  logic [7:0]        rxByte, txShift;
  logic [HI_W-1:0]   addrHi;
  logic [ADDR_W-1:0] addrCnt;
  logic [6:0]        savedDev;
  sdaMode_t          sdaMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= '0;
      bitCnt  <= '0;
    end else if (strb.clrBit) begin
      bitCnt <= '0;
    end else if (strb.shiftIn) begin
      rxByte <= {rxByte[6:0], sdaSync};
      bitCnt <= bitCnt + 4'd1;
    end else if (strb.loadTx) begin
      txShift <= memArr[addrCnt];
      bitCnt  <= '0;
    end else if (strb.shiftTx) begin
      txShift <= {txShift[6:0], 1'b0};
      bitCnt  <= bitCnt + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi   <= '0;
      addrCnt  <= '0;
      savedDev <= '0;
    end else begin
      if (strb.latchHi)  addrHi   <= rxByte[HI_W-1:0];
      if (strb.saveDev)  savedDev <= rxByte[7:1];
      if (strb.loadAddr) addrCnt  <= {addrHi, rxByte};
      else if (strb.loadTx) addrCnt <= addrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sdaMode <= SDA_REL;
    else if (strb.relSda) sdaMode <= SDA_REL;
    else if (strb.drvAck) sdaMode <= SDA_ACK;
    else if (strb.loadTx) sdaMode <= SDA_DATA;
  end

  assign rwBit       = rxByte[0];
  assign devMatch    = (rxByte[7:1] == {DEV_TYPE, chipSel});
  assign sameDev     = (rxByte[7:1] == savedDev);
  assign sdaDriveLow = (sdaMode == SDA_ACK) || ((sdaMode == SDA_DATA) && !txShift[7]);

  // ---------------- assertions ----------------
  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDriveLow);

  // drive changes only after an SCL fall, except when a bus event forces release
  assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaDriveLow) && !$past(startDet || stopDet)) |-> !sclPrev);

  assert_bitcnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8);

endmodule

// File: rtl/twimem_ctrl.sv
module twimem_ctrl
  import twimem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaSync,
  input  logic       rwBit,
  input  logic [3:0] bitCnt,
  input  logic       devMatch,
  input  logic       sameDev,
  output dpStrobe_t  strb
);

  ctrlState_t state, stateNxt;
  logic dummyOpen, dummyNxt;
  logic mAck, mAckNxt;
  logic byteIn;

  assign byteIn = sclFall && (bitCnt == 4'd8);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dummyOpen <= 1'b0;
      mAck      <= 1'b0;
    end else begin
      state     <= stateNxt;
      dummyOpen <= dummyNxt;
      mAck      <= mAckNxt;
    end
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    dummyNxt = dummyOpen;
    mAckNxt  = mAck;
    if (stopDet) begin
      strb.relSda = 1'b1;
      stateNxt    = ST_IDLE;
      dummyNxt    = 1'b0;
    end else if (startDet) begin
      strb.relSda = 1'b1;
      strb.clrBit = 1'b1;
      stateNxt    = ST_DEV;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_DEV: begin
          if (sclRise) strb.shiftIn = 1'b1;
          else if (byteIn) begin
            if (devMatch && (!rwBit || !dummyOpen || sameDev)) begin
              strb.drvAck = 1'b1;
              stateNxt    = ST_DEV_ACK;
              if (!rwBit) begin
                strb.saveDev = 1'b1;
                dummyNxt     = 1'b1;
              end else begin
                dummyNxt = 1'b0;
              end
            end else begin
              stateNxt = ST_IDLE;
              dummyNxt = 1'b0;
            end
          end
        end
        ST_DEV_ACK: begin
          if (sclFall) begin
            if (rwBit) begin
              strb.loadTx = 1'b1;
              stateNxt    = ST_TX;
            end else begin
              strb.relSda = 1'b1;
              strb.clrBit = 1'b1;
              stateNxt    = ST_AHI;
            end
          end
        end
        ST_AHI: begin
          if (sclRise) strb.shiftIn = 1'b1;
          else if (byteIn) begin
            strb.latchHi = 1'b1;
            strb.drvAck  = 1'b1;
            stateNxt     = ST_AHI_ACK;
          end
        end
        ST_AHI_ACK: begin
          if (sclFall) begin
            strb.relSda = 1'b1;
            strb.clrBit = 1'b1;
            stateNxt    = ST_ALO;
          end
        end
        ST_ALO: begin
          if (sclRise) strb.shiftIn = 1'b1;
          else if (byteIn) begin
            strb.loadAddr = 1'b1;
            strb.drvAck   = 1'b1;
            stateNxt      = ST_ALO_ACK;
          end
        end
        ST_ALO_ACK: begin
          if (sclFall) begin
            strb.relSda = 1'b1;
            strb.clrBit = 1'b1;
            stateNxt    = ST_WDAT;
          end
        end
        ST_WDAT: begin
          if (sclRise) strb.shiftIn = 1'b1;
          else if (byteIn) begin
            strb.drvAck = 1'b1;
            stateNxt    = ST_WDAT_ACK;
          end
        end
        ST_WDAT_ACK: begin
          if (sclFall) begin
            strb.relSda = 1'b1;
            strb.clrBit = 1'b1;
            stateNxt    = ST_WDAT;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              strb.relSda = 1'b1;
              stateNxt    = ST_MACK;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) mAckNxt = !sdaSync;
          else if (sclFall) begin
            if (mAck) begin
              strb.loadTx = 1'b1;
              stateNxt    = ST_TX;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_sda_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.drvAck, strb.relSda, strb.loadTx}));

  // master acknowledge slot only after all eight data bits were shifted out
  assert_mack_after_eight_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MACK) |-> (bitCnt == 4'd7));

  // every acknowledge slot follows a complete eight-bit reception
  assert_ack_full_byte_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV_ACK || state == ST_AHI_ACK || state == ST_ALO_ACK ||
     state == ST_WDAT_ACK) |-> (bitCnt == 4'd8));

endmodule

// File: rtl/twimem_read_slave.sv
module twimem_read_slave
  import twimem_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [2:0]        chipSel,
  input  logic              writeCtl,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData
);

  dpStrobe_t  strb;
  logic       sclRise, sclFall, startDet, stopDet, sdaSync, rwBit;
  logic       devMatch, sameDev;
  logic [3:0] bitCnt;

  // reads never depend on the write-control pin
  logic unusedWc;
  assign unusedWc = writeCtl;

  twimem_datapath #(
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .chipSel     (chipSel),
    .loadEn      (loadEn),
    .loadAddr    (loadAddr),
    .loadData    (loadData),
    .strb        (strb),
    .sclRise     (sclRise),
    .sclFall     (sclFall),
    .startDet    (startDet),
    .stopDet     (stopDet),
    .sdaSync     (sdaSync),
    .rwBit       (rwBit),
    .bitCnt      (bitCnt),
    .devMatch    (devMatch),
    .sameDev     (sameDev),
    .sdaDriveLow (sdaDriveLow)
  );

  twimem_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaSync  (sdaSync),
    .rwBit    (rwBit),
    .bitCnt   (bitCnt),
    .devMatch (devMatch),
    .sameDev  (sameDev),
    .strb     (strb)
  );

endmodule

// File: tb/tb_twimem_read_slave.sv
module tb_twimem_read_slave;

  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaDriveLow;
  wire  sdaLine = sdaM & ~sdaDriveLow;
  logic [2:0]    chipSel  = 3'd3;
  logic          writeCtl = 1'b0;
  logic          loadEn   = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic [7:0]    loadData = '0;

  twimem_read_slave #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .chipSel(chipSel), .writeCtl(writeCtl),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData)
  );

  int total = 0, bad = 0, sclViol = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      req;
  } expItem_t;
  expItem_t   expQ[$];
  logic [7:0] actQ[$];
  logic [7:0] gotByte;
  expItem_t   expItem;
  logic [7:0] memShadow [DEPTH];

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) ^ (a >> 4));
  endfunction

  function automatic logic [7:0] devByte(logic [2:0] cs, logic rw);
    return {4'b1010, cs, rw};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- bit-level master ----------------
  task automatic qtr();
    repeat (8) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; qtr(); sclM = 1'b1; qtr(); sdaM = 1'b0; qtr(); sclM = 1'b0; qtr();
  endtask

  task automatic busStop();
    sdaM = 1'b0; qtr(); sclM = 1'b1; qtr(); sdaM = 1'b1; qtr();
  endtask

  task automatic sendBit(logic b);
    sdaM = b; qtr(); sclM = 1'b1; qtr(); qtr(); sclM = 1'b0; qtr();
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; qtr(); sclM = 1'b1; qtr(); b = sdaLine; qtr(); sclM = 1'b0; qtr();
  endtask

  task automatic writeByte(logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    acked = ~b;
  endtask

  task automatic readByte(logic ackIt);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    actQ.push_back(d);
    sendBit(~ackIt);
  endtask

  // ---------------- transaction helpers ----------------
  task automatic readBytes(int firstAddr, int n, string req);
    for (int i = 0; i < n; i++) begin
      expQ.push_back('{memShadow[(firstAddr + i) % DEPTH], req});
      readByte(i < n - 1);
    end
  endtask

  task automatic currentRead(int firstAddr, int n, string req);
    logic ack;
    busStart();
    writeByte(devByte(chipSel, 1'b1), ack);
    check({req, " read select ack"}, int'(ack), 1);
    readBytes(firstAddr, n, req);
    busStop();
  endtask

  task automatic sendAddr(int a, string req);
    logic ack;
    writeByte(devByte(chipSel, 1'b0), ack);
    check({req, " write select ack"}, int'(ack), 1);
    writeByte(8'(a >> 8), ack);
    check({req, " high address ack"}, int'(ack), 1);
    writeByte(8'(a), ack);
    check({req, " low address ack"}, int'(ack), 1);
  endtask

  task automatic randomRead(int a, int n, string req);
    logic ack;
    busStart();
    sendAddr(a, req);
    busStart();
    writeByte(devByte(chipSel, 1'b1), ack);
    check({req, " repeated select ack"}, int'(ack), 1);
    readBytes(a % DEPTH, n, req);
    busStop();
  endtask

  // ---------------- scoreboard monitor ----------------
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (actQ.size() > 0) begin
        gotByte = actQ.pop_front();
        if (expQ.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R7 unexpected byte actual=%0h expected=none", gotByte);
        end else begin
          expItem = expQ.pop_front();
          check(expItem.req, int'(gotByte), int'(expItem.val));
        end
      end
    end
  end

  // SDA drive may change only while SCL is low (R11)
  logic prevDrv = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sdaDriveLow !== prevDrv && sclM) sclViol++;
      prevDrv = sdaDriveLow;
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    #2;
    check("R1 SDA released in reset", int'(sdaDriveLow), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R1 SDA released after reset", int'(sdaDriveLow), 0);

    // R12: backdoor preload
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      loadEn   = 1'b1;
      loadAddr = AW'(i);
      loadData = pat(i);
      memShadow[i] = pat(i);
    end
    @(negedge clk);
    loadEn = 1'b0;
    qtr();

    currentRead(0, 1, "R1 R5 first current read");
    currentRead(1, 1, "R5 R6 counter persists");

    writeCtl = 1'b1;  // R10: reads ignore write control
    randomRead(16'h0123, 3, "R4 R7 R10 sequential random read");
    currentRead(16'h126, 1, "R6 R10 counter after sequence");
    writeCtl = 1'b0;

    randomRead(16'hFFFE, 3, "R6 wrap FFF to 000");

    // R3: select mismatches are not acknowledged
    busStart();
    writeByte(devByte(3'd6, 1'b1), ack);
    check("R3 wrong chip enable nack", int'(ack), 0);
    busStop();
    busStart();
    writeByte(8'hB7, ack);
    check("R3 wrong type nibble nack", int'(ack), 0);
    busStop();
    currentRead(1, 1, "R3 counter untouched by rejected select");

    // R8: repeated select differs from the first one
    busStart();
    sendAddr(16'h0200, "R8");
    chipSel = 3'd5;
    busStart();
    writeByte(devByte(3'd5, 1'b1), ack);
    check("R8 differing repeated select nack", int'(ack), 0);
    busStop();
    chipSel = 3'd3;
    currentRead(16'h200, 1, "R4 R8 dummy write loaded counter");

    // R9: write data acknowledged, not stored
    busStart();
    sendAddr(16'h0050, "R9");
    writeByte(8'h5A, ack);
    check("R9 write data ack", int'(ack), 1);
    busStop();
    currentRead(16'h050, 1, "R9 data not stored, counter not moved");

    // R2: START between the address bytes abandons the dummy write
    busStart();
    writeByte(devByte(chipSel, 1'b0), ack);
    check("R2 write select ack", int'(ack), 1);
    writeByte(8'h07, ack);
    check("R2 high address ack", int'(ack), 1);
    busStart();
    writeByte(devByte(chipSel, 1'b1), ack);
    check("R2 read select after cut-off ack", int'(ack), 1);
    readBytes(16'h051, 1, "R2 counter unchanged by partial address");
    busStop();

    // R2: STOP right after a write select
    busStart();
    writeByte(devByte(chipSel, 1'b0), ack);
    check("R2 select ack before stop", int'(ack), 1);
    busStop();
    qtr();
    check("R2 SDA released after stop", int'(sdaDriveLow), 0);

    // R12: late backdoor rewrite is returned
    @(negedge clk);
    loadEn = 1'b1; loadAddr = AW'(16'h052); loadData = 8'hC3;
    memShadow[16'h052] = 8'hC3;
    @(negedge clk);
    loadEn = 1'b0;
    currentRead(16'h052, 1, "R12 backdoor rewrite");

    repeat (20) @(negedge clk);
    check("R7 scoreboard drained", expQ.size(), 0);
    check("R11 SDA changed while SCL high", sclViol, 0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule